// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block steers a multicycle processor datapath from a small constant microcode store. A micro-PC selects one microinstruction per clock. The microinstruction is made of seven symbolic fields:

- ALU operation
- first ALU operand
- second ALU operand
- register-file action
- memory action
- PC update
- next-address selection

A field decoder turns these fields into the individual datapath controls. A sequencer picks the next micro-address. It can step to the following entry, jump back to the fetch entry, or branch through one of two dispatch tables that are indexed by the 6-bit opcode of the instruction currently held in the instruction register.

The store has nine named entries, at micro-addresses 0 to 8:

| Address | Entry |
|---|---|
| 0 | FETCH |
| 1 | DECODE |
| 2 | BEQ1 |
| 3 | RT_EXEC |
| 4 | RT_WB |
| 5 | MEM_ADDR |
| 6 | LW_READ |
| 7 | LW_WB |
| 8 | SW_WRITE |

The transitions are:

- FETCH steps to DECODE.
- DECODE dispatches to BEQ1, RT_EXEC or MEM_ADDR.
- RT_EXEC steps to RT_WB.
- MEM_ADDR dispatches to LW_READ or SW_WRITE.
- LW_READ steps to LW_WB.
- BEQ1, RT_WB, LW_WB and SW_WRITE return to FETCH.
- A failed dispatch also returns to FETCH.

The output codes are:

- ALU operation: 00 add, 01 subtract, 10 function-field.
- Second-operand select: 00 B, 01 constant four, 10 sign-extended immediate, 11 shifted sign-extended immediate.

A blank field drives every control it governs to 0.

Top module: `uctl_top`

## Requirements
- R1: When rst_n is low, upc is 0 at once and the outputs show the FETCH controls. After release, the sequence starts at FETCH.
- R2: In FETCH, the outputs are mem_rd=1, ir_load=1, pc_load=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01 and alu_op=00, and all other controls are 0. The next entry is DECODE (1).
- R3: In DECODE, alu_b_sel=11 and every other control is 0. The next entry is BEQ1 (2) for opcode 4, RT_EXEC (3) for opcode 0, and MEM_ADDR (5) for opcodes 35 and 43.
- R4: In BEQ1, alu_a_sel=1, alu_b_sel=00, alu_op=01 and pc_src=1. pc_load equals alu_zero in the same cycle. The next entry is FETCH.
- R5: In RT_EXEC, alu_a_sel=1, alu_b_sel=00 and alu_op=10, and the next entry is RT_WB. In RT_WB, reg_wr=1, dst_sel=1 and wb_sel=0, and the next entry is FETCH.
- R6: In MEM_ADDR, alu_a_sel=1, alu_b_sel=10 and alu_op=00. The next entry is LW_READ (6) for opcode 35 and SW_WRITE (8) for opcode 43.
- R7: In LW_READ, mem_rd=1 and addr_sel=1, and the next entry is LW_WB. In LW_WB, reg_wr=1, wb_sel=1 and dst_sel=0, and the next entry is FETCH.
- R8: In SW_WRITE, mem_wr=1 and addr_sel=1, and the next entry is FETCH.
- R9: An opcode that is absent from the active dispatch table sends the sequencer to FETCH. Outside BEQ1, alu_zero has no effect on any output.
- R10: mem_rd and mem_wr are never both 1, and ir_load is 1 only in FETCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_zero | input | 1 | ALU zero flag from the datapath |
| upc | output | 4 | Current micro-address |
| pc_load | output | 1 | Load the program counter |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Load the instruction register |
| reg_wr | output | 1 | Register-file write |
| dst_sel | output | 1 | Destination: 0 rt field, 1 rd field |
| wb_sel | output | 1 | Write-back data: 0 ALU output, 1 memory data register |
| alu_a_sel | output | 1 | First operand: 0 PC, 1 A |
| alu_b_sel | output | 2 | Second operand select |
| alu_op | output | 2 | ALU operation code |

## Verification
The checks assume that the opcode stays the same from the end of FETCH until the instruction returns to FETCH, because the instruction register only loads in FETCH. They also assume that alu_zero is settled before the clock edge that ends BEQ1. The stimulus only changes the opcode at the start of a FETCH cycle, and it drives alu_zero to both values around branch completions. Because the opcode is held for the whole instruction, a miss in the second dispatch table cannot be reached, so R9 is exercised through the first table using unused opcodes.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

    localparam int UA_W = 4;

    // Micro-address labels of the store
    typedef enum logic [UA_W-1:0] {
        UA_FETCH    = 4'd0,
        UA_DECODE   = 4'd1,
        UA_BEQ1     = 4'd2,
        UA_RT_EXEC  = 4'd3,
        UA_RT_WB    = 4'd4,
        UA_MEM_ADDR = 4'd5,
        UA_LW_READ  = 4'd6,
        UA_LW_WB    = 4'd7,
        UA_SW_WRITE = 4'd8
    } uaddr_e;

    typedef enum logic [1:0] {ALU_NONE, ALU_ADD, ALU_SUB, ALU_FUNC} alu_fld_e;
    typedef enum logic [1:0] {OPA_NONE, OPA_PC, OPA_REG} opa_fld_e;
    typedef enum logic [2:0] {OPB_NONE, OPB_REG, OPB_FOUR, OPB_IMM, OPB_IMM_SH} opb_fld_e;
    typedef enum logic [1:0] {RF_NONE, RF_READ, RF_WR_ALU, RF_WR_MDR} rf_fld_e;
    typedef enum logic [1:0] {MEM_NONE, MEM_RD_PC, MEM_RD_ALU, MEM_WR_ALU} mem_fld_e;
    typedef enum logic [1:0] {PCW_NONE, PCW_ALU, PCW_ALU_ZERO} pcw_fld_e;
    typedef enum logic [1:0] {NX_SEQ, NX_FETCH, NX_DISP1, NX_DISP2} nx_fld_e;

    typedef struct packed {
        alu_fld_e alu;
        opa_fld_e opa;
        opb_fld_e opb;
        rf_fld_e  rf;
        mem_fld_e mem;
        pcw_fld_e pcw;
        nx_fld_e  nx;
    } uinstr_t;

    localparam logic [1:0] ALUOP_ADD  = 2'b00;
    localparam logic [1:0] ALUOP_SUB  = 2'b01;
    localparam logic [1:0] ALUOP_FUNC = 2'b10;

    localparam logic [1:0] BSEL_REG    = 2'b00;
    localparam logic [1:0] BSEL_FOUR   = 2'b01;
    localparam logic [1:0] BSEL_IMM    = 2'b10;
    localparam logic [1:0] BSEL_IMM_SH = 2'b11;

endpackage

// File: rtl/uctl_ustore.sv
module uctl_ustore
    import uctl_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uinstr_t         word
);
    always_comb begin
        word = '{ALU_NONE, OPA_NONE, OPB_NONE, RF_NONE, MEM_NONE, PCW_NONE, NX_FETCH};
        unique case (addr)
            UA_FETCH:    word = '{ALU_ADD,  OPA_PC,   OPB_FOUR,   RF_NONE,   MEM_RD_PC,  PCW_ALU,      NX_SEQ};
            UA_DECODE:   word = '{ALU_ADD,  OPA_PC,   OPB_IMM_SH, RF_READ,   MEM_NONE,   PCW_NONE,     NX_DISP1};
            UA_BEQ1:     word = '{ALU_SUB,  OPA_REG,  OPB_REG,    RF_NONE,   MEM_NONE,   PCW_ALU_ZERO, NX_FETCH};
            UA_RT_EXEC:  word = '{ALU_FUNC, OPA_REG,  OPB_REG,    RF_NONE,   MEM_NONE,   PCW_NONE,     NX_SEQ};
            UA_RT_WB:    word = '{ALU_NONE, OPA_NONE, OPB_NONE,   RF_WR_ALU, MEM_NONE,   PCW_NONE,     NX_FETCH};
            UA_MEM_ADDR: word = '{ALU_ADD,  OPA_REG,  OPB_IMM,    RF_NONE,   MEM_NONE,   PCW_NONE,     NX_DISP2};
            UA_LW_READ:  word = '{ALU_NONE, OPA_NONE, OPB_NONE,   RF_NONE,   MEM_RD_ALU, PCW_NONE,     NX_SEQ};
            UA_LW_WB:    word = '{ALU_NONE, OPA_NONE, OPB_NONE,   RF_WR_MDR, MEM_NONE,   PCW_NONE,     NX_FETCH};
            UA_SW_WRITE: word = '{ALU_NONE, OPA_NONE, OPB_NONE,   RF_NONE,   MEM_WR_ALU, PCW_NONE,     NX_FETCH};
            default:     word = '{ALU_NONE, OPA_NONE, OPB_NONE,   RF_NONE,   MEM_NONE,   PCW_NONE,     NX_FETCH};
        endcase
    end
endmodule

// File: rtl/uctl_dispatch.sv
module uctl_dispatch
    import uctl_pkg::*;
#(
    parameter int              OP_W     = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 0,
    parameter logic [OP_W-1:0] OP_BEQ   = 4,
    parameter logic [OP_W-1:0] OP_LW    = 35,
    parameter logic [OP_W-1:0] OP_SW    = 43
) (
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] tgt_d1,
    output logic [UA_W-1:0] tgt_d2
);
    // First table: chosen after decode
    always_comb begin
        tgt_d1 = UA_FETCH;
        if (opcode == OP_BEQ)
            tgt_d1 = UA_BEQ1;
        else if (opcode == OP_RTYPE)
            tgt_d1 = UA_RT_EXEC;
        else if (opcode == OP_LW || opcode == OP_SW)
            tgt_d1 = UA_MEM_ADDR;
    end

    // Second table: chosen after address computation
    always_comb begin
        tgt_d2 = UA_FETCH;
        if (opcode == OP_LW)
            tgt_d2 = UA_LW_READ;
        else if (opcode == OP_SW)
            tgt_d2 = UA_SW_WRITE;
    end
endmodule

// File: rtl/uctl_useq.sv
module uctl_useq
    import uctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  nx_fld_e         nx_sel,
    input  logic [UA_W-1:0] tgt_d1,
    input  logic [UA_W-1:0] tgt_d2,
    output logic [UA_W-1:0] upc
);
    logic [UA_W-1:0] upc_nxt;

    always_comb begin
        unique case (nx_sel)
            NX_SEQ:   upc_nxt = upc + 1'b1;
            NX_FETCH: upc_nxt = UA_FETCH;
            NX_DISP1: upc_nxt = tgt_d1;
            NX_DISP2: upc_nxt = tgt_d2;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            upc <= UA_FETCH;
        else
            upc <= upc_nxt;
    end
endmodule

// File: rtl/uctl_decode.sv
module uctl_decode
    import uctl_pkg::*;
(
    input  uinstr_t    word,
    input  logic       alu_zero,
    output logic       pc_load,
    output logic       pc_src,
    output logic       addr_sel,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       ir_load,
    output logic       reg_wr,
    output logic       dst_sel,
    output logic       wb_sel,
    output logic       alu_a_sel,
    output logic [1:0] alu_b_sel,
    output logic [1:0] alu_op
);
    always_comb begin
        unique case (word.alu)
            ALU_SUB:  alu_op = ALUOP_SUB;
            ALU_FUNC: alu_op = ALUOP_FUNC;
            default:  alu_op = ALUOP_ADD;
        endcase
    end

    assign alu_a_sel = (word.opa == OPA_REG);

    always_comb begin
        unique case (word.opb)
            OPB_FOUR:   alu_b_sel = BSEL_FOUR;
            OPB_IMM:    alu_b_sel = BSEL_IMM;
            OPB_IMM_SH: alu_b_sel = BSEL_IMM_SH;
            default:    alu_b_sel = BSEL_REG;
        endcase
    end

    always_comb begin
        reg_wr  = 1'b0;
        dst_sel = 1'b0;
        wb_sel  = 1'b0;
        unique case (word.rf)
            RF_WR_ALU: begin reg_wr = 1'b1; dst_sel = 1'b1; end
            RF_WR_MDR: begin reg_wr = 1'b1; wb_sel  = 1'b1; end
            default:   ;
        endcase
    end

    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        ir_load  = 1'b0;
        addr_sel = 1'b0;
        unique case (word.mem)
            MEM_RD_PC:  begin mem_rd = 1'b1; ir_load  = 1'b1; end
            MEM_RD_ALU: begin mem_rd = 1'b1; addr_sel = 1'b1; end
            MEM_WR_ALU: begin mem_wr = 1'b1; addr_sel = 1'b1; end
            default:    ;
        endcase
    end

    always_comb begin
        pc_load = 1'b0;
        pc_src  = 1'b0;
        unique case (word.pcw)
            PCW_ALU:      pc_load = 1'b1;
            PCW_ALU_ZERO: begin pc_load = alu_zero; pc_src = 1'b1; end
            default:      ;
        endcase
    end
endmodule

// File: rtl/uctl_top.sv
module uctl_top
    import uctl_pkg::*;
#(
    parameter int              OP_W     = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 0,
    parameter logic [OP_W-1:0] OP_BEQ   = 4,
    parameter logic [OP_W-1:0] OP_LW    = 35,
    parameter logic [OP_W-1:0] OP_SW    = 43
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    output logic [UA_W-1:0] upc,
    output logic            pc_load,
    output logic            pc_src,
    output logic            addr_sel,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_load,
    output logic            reg_wr,
    output logic            dst_sel,
    output logic            wb_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op
);
    uinstr_t         word;
    logic [UA_W-1:0] tgt_d1;
    logic [UA_W-1:0] tgt_d2;

    uctl_ustore u_store (
        .addr (upc),
        .word (word)
    );

    uctl_dispatch #(
        .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_BEQ(OP_BEQ),
        .OP_LW(OP_LW), .OP_SW(OP_SW)
    ) u_disp (
        .opcode (opcode),
        .tgt_d1 (tgt_d1),
        .tgt_d2 (tgt_d2)
    );

    uctl_useq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .nx_sel (word.nx),
        .tgt_d1 (tgt_d1),
        .tgt_d2 (tgt_d2),
        .upc    (upc)
    );

    uctl_decode u_dec (
        .word      (word),
        .alu_zero  (alu_zero),
        .pc_load   (pc_load),
        .pc_src    (pc_src),
        .addr_sel  (addr_sel),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .ir_load   (ir_load),
        .reg_wr    (reg_wr),
        .dst_sel   (dst_sel),
        .wb_sel    (wb_sel),
        .alu_a_sel (alu_a_sel),
        .alu_b_sel (alu_b_sel),
        .alu_op    (alu_op)
    );
endmodule

// File: rtl/uctl_chk.sv
module uctl_chk #(
    parameter int              OP_W     = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 0,
    parameter logic [OP_W-1:0] OP_BEQ   = 4,
    parameter logic [OP_W-1:0] OP_LW    = 35,
    parameter logic [OP_W-1:0] OP_SW    = 43
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] opcode,
    input logic            alu_zero,
    input logic [3:0]      upc,
    input logic            pc_load,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            ir_load
);
    logic op_known;
    assign op_known = (opcode == OP_RTYPE) || (opcode == OP_BEQ) ||
                      (opcode == OP_LW) || (opcode == OP_SW);

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd0 |=> upc == 4'd1); // R2
    AST_DECODE_BEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd1 && opcode == OP_BEQ) |=> upc == 4'd2); // R3
    AST_BEQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd2 |-> pc_load == alu_zero); // R4
    AST_RT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd3 |=> upc == 4'd4); // R5
    AST_MEM_TO_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd5 && opcode == OP_SW) |=> upc == 4'd8); // R6
    AST_LW_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd6 |=> upc == 4'd7); // R7
    AST_SW_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd8 |=> upc == 4'd0); // R8
    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd1 && !op_known) |=> upc == 4'd0); // R9
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10
    AST_IR_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> upc == 4'd0); // R10
endmodule

bind uctl_top uctl_chk #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_BEQ(OP_BEQ), .OP_LW(OP_LW), .OP_SW(OP_SW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .upc(upc),
    .pc_load(pc_load), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load)
);

// File: tb/uctl_top_tb.sv
module uctl_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic       alu_zero = 1'b0;
    logic [3:0] upc;
    logic       pc_load, pc_src, addr_sel, mem_rd, mem_wr, ir_load;
    logic       reg_wr, dst_sel, wb_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op;

    int checks = 0;
    int fails  = 0;
    int mpc    = 0;

    always #10 clk = ~clk;

    uctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .upc(upc),
        .pc_load(pc_load), .pc_src(pc_src), .addr_sel(addr_sel), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ir_load(ir_load), .reg_wr(reg_wr), .dst_sel(dst_sel),
        .wb_sel(wb_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op)
    );

    // {pc_load,pc_src,addr_sel,mem_rd,mem_wr,ir_load,reg_wr,dst_sel,wb_sel,a_sel,b_sel,op}
    function automatic logic [13:0] expect_ctl(int m, logic z);
        case (m)
            0: return 14'b1_0_0_1_0_1_0_0_0_0_01_00;          // R2
            1: return 14'b0_0_0_0_0_0_0_0_0_0_11_00;          // R3
            2: return {z, 13'b1_0_0_0_0_0_0_0_1_00_01};       // R4
            3: return 14'b0_0_0_0_0_0_0_0_0_1_00_10;          // R5
            4: return 14'b0_0_0_0_0_0_1_1_0_0_00_00;          // R5
            5: return 14'b0_0_0_0_0_0_0_0_0_1_10_00;          // R6
            6: return 14'b0_0_1_1_0_0_0_0_0_0_00_00;          // R7
            7: return 14'b0_0_0_0_0_0_1_0_1_0_00_00;          // R7
            8: return 14'b0_0_1_0_1_0_0_0_0_0_00_00;          // R8
            default: return 14'h3fff;
        endcase
    endfunction

    function automatic int next_mpc(int m, int op);
        case (m)
            0: return 1;
            1: if (op == 4) return 2;
               else if (op == 0) return 3;
               else if (op == 35 || op == 43) return 5;
               else return 0;                               // R9
            3: return 4;
            5: if (op == 35) return 6;
               else if (op == 43) return 8;
               else return 0;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int m, int op);
        case (m)
            0: return "R2";
            1: return (op == 0 || op == 4 || op == 35 || op == 43) ? "R3" : "R9";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [13:0] actual_ctl();
        return {pc_load, pc_src, addr_sel, mem_rd, mem_wr, ir_load, reg_wr,
                dst_sel, wb_sel, alu_a_sel, alu_b_sel, alu_op};
    endfunction

    task automatic check(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s upc=%0d actual=%b expected=%b", req, upc, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge
    task automatic run_cycle(int op, logic z);
        string r;
        opcode   = 6'(op);
        alu_zero = z;
        #1;
        r = req_of(mpc, op);
        check(r, {10'd0, upc}, 14'(mpc));
        check(r, actual_ctl(), expect_ctl(mpc, z));
        check("R10", {13'd0, mem_rd & mem_wr}, 14'd0);
        mpc = next_mpc(mpc, op);
        @(negedge clk);
    endtask

    task automatic run_instr(int op, logic z);
        do run_cycle(op, z); while (mpc != 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int ops[10] = '{0, 4, 4, 35, 43, 7, 63, 0, 35, 43};
        logic zs[10] = '{1, 1, 0, 1, 0, 1, 1, 0, 1, 1};
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R1", {10'd0, upc}, 14'd0);
        check("R1", actual_ctl(), expect_ctl(0, 1'b0));
        @(negedge clk);
        rst_n = 1'b1;
        mpc = 0;
        for (int i = 0; i < 10; i++) run_instr(ops[i], zs[i]);
        // reset in the middle of a load
        run_cycle(35, 1'b0);
        run_cycle(35, 1'b0);
        run_cycle(35, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1", {10'd0, upc}, 14'd0);
        check("R1", actual_ctl(), expect_ctl(0, 1'b0));
        @(negedge clk);
        rst_n = 1'b1;
        mpc = 0;
        run_instr(0, 1'b1);
        run_instr(4, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule